// File: doc/BRIEF.md
# Block Lock Register Updater

This block moves one flash block's lock register from its present setting to a requested one, over a simple single-outstanding register bus. The caller supplies the register address, the value it last read there and either a requested value or an unlock command. The block screens the request, then issues a short series of write/read-back pairs in an order that never fixes the lockdown state before the access bits are right. It ends with a one-cycle completion pulse and a result code.

The lock field is three bits: bit 0 blocks writes, bit 2 blocks reads, and bit 1 is lockdown, which freezes the other two and is normally irreversible once set. An attempt to clear lockdown is still made when the request asks for it, but the outcome is checked before anything else is touched. Bits above bit 2 are not lock bits and must not change.

Top module: `lockupd_ctrl`

## Requirements
- R1: The lock field is bits 2:0 of the register: bit 0 write lock, bit 1 lockdown, bit 2 read lock. Result codes on `err_code`: 0 success, 1 rejected request, 2 lockdown would not clear, 3 access-bit read-back mismatch, 4 lockdown-set read-back mismatch.
- R2: A target that differs from the current value in any bit above bit 2 completes with code 1 and no bus access.
- R3: A target equal to the current value in bits 2:0 completes with code 0 and no bus access.
- R4: When the current value has lockdown set and the target clears it, the first write is the current value with only bit 1 cleared; if its read-back still shows bit 1 set, the operation ends with code 2 and no further write.
- R5: Access-bit changes are written with bit 1 at its value after any lockdown-clear step, and the read-back must equal the written value exactly, otherwise the operation ends with code 3.
- R6: Lockdown is set only by a final, separate write of the full target once bits 0 and 2 already match it; a read-back differing from the target ends the operation with code 4.
- R7: Every write is followed by exactly one read of the same address before the next write or the completion.
- R8: With `unlock` high the target is the current value with bits 0 and 2 cleared and every other bit kept; `req_val` is ignored.
- R9: `bus_addr`, `bus_we` and `bus_wdata` hold steady while `bus_req` is high and `bus_ack` has not been given.
- R10: `done` is a single-cycle pulse per accepted operation, one cycle after the start for screened results and one cycle after the last read acknowledge otherwise; `start` is ignored while an operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| unlock | input | 1 | Use the unlock target instead of `req_val` |
| addr_in | input | AW | Lock register address |
| cur_val | input | DW | Present register value |
| req_val | input | DW | Requested register value |
| done | output | 1 | Completion pulse |
| err_code | output | 3 | Result code, valid with `done` |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with `bus_ack` on a read |
| bus_ack | input | 1 | Access complete |

## Verification
The bench drives a register model that can refuse to clear lockdown, refuse access-bit changes or refuse to set lockdown, and logs every access. A design that set lockdown together with the access bits would show one write where two are expected; one that skipped the lockdown check would write again after a stuck clear instead of stopping with code 2. Upper-bit mismatches and no-op requests must produce no access at all, and the unlock command must ignore the requested value and keep lockdown, which a design reading `req_val` would get wrong. A second start during a busy operation and slow acknowledges probe the handshake and the single completion pulse.

// File: rtl/lockupd_pkg.sv
package lockupd_pkg;
    localparam int WL_BIT = 0;
    localparam int LD_BIT = 1;
    localparam int RL_BIT = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD} st_e;
    typedef enum logic [1:0] {PH_CLRLD, PH_RW, PH_SETLD, PH_NONE} ph_e;
    typedef enum logic [2:0] {
        E_OK      = 3'd0,
        E_BADREQ  = 3'd1,
        E_LDSTUCK = 3'd2,
        E_RWFAIL  = 3'd3,
        E_LDFAIL  = 3'd4
    } err_e;
endpackage

// File: rtl/lockupd_screen.sv
module lockupd_screen
    import lockupd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] req,
    input  logic          unlock,
    output logic [DW-1:0] tgt,
    output logic          bad,
    output logic          same
);
    localparam logic [DW-1:0] ACC_M  = DW'((1 << WL_BIT) | (1 << RL_BIT));
    localparam logic [DW-1:0] FULL_M = ACC_M | DW'(1 << LD_BIT);

    always_comb begin
        // unlock drops both access bits and keeps everything else
        tgt  = unlock ? (cur & ~ACC_M) : req;
        bad  = |((cur ^ tgt) & ~FULL_M);
        same = ~|((cur ^ tgt) & FULL_M);
    end
endmodule

// File: rtl/lockupd_step.sv
module lockupd_step
    import lockupd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] work,
    input  logic [DW-1:0] tgt,
    output ph_e           ph,
    output logic [DW-1:0] wval
);
    localparam logic [DW-1:0] ACC_M = DW'((1 << WL_BIT) | (1 << RL_BIT));
    localparam logic [DW-1:0] LD_M  = DW'(1 << LD_BIT);

    // Priority: release lockdown, then access bits, then lockdown set.
    always_comb begin
        ph   = PH_NONE;
        wval = work;
        if (work[LD_BIT] && !tgt[LD_BIT]) begin
            ph   = PH_CLRLD;
            wval = work & ~LD_M;
        end else if (|((work ^ tgt) & ACC_M)) begin
            ph   = PH_RW;
            wval = (work & ~ACC_M) | (tgt & ACC_M);
        end else if (!work[LD_BIT] && tgt[LD_BIT]) begin
            ph   = PH_SETLD;
            wval = tgt;
        end
    end
endmodule

// File: rtl/lockupd_ctrl.sv
module lockupd_ctrl
    import lockupd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          unlock,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] cur_val,
    input  logic [DW-1:0] req_val,
    output logic          done,
    output logic [2:0]    err_code,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack
);
    localparam logic [DW-1:0] ACC_M = DW'((1 << WL_BIT) | (1 << RL_BIT));
    localparam logic [DW-1:0] LD_M  = DW'(1 << LD_BIT);

    typedef struct packed {
        st_e           st;
        ph_e           ph;
        logic [DW-1:0] tgt;
        logic [DW-1:0] wval;
        logic [AW-1:0] addr;
        logic          done;
        err_e          err;
    } regs_t;

    regs_t q, d;

    logic [DW-1:0] scr_tgt;
    logic          scr_bad, scr_same;
    logic [DW-1:0] stp_work, stp_tgt, stp_wval;
    ph_e           stp_ph;
    logic          rd_fail;

    lockupd_screen #(.DW(DW)) u_screen (
        .cur    (cur_val),
        .req    (req_val),
        .unlock (unlock),
        .tgt    (scr_tgt),
        .bad    (scr_bad),
        .same   (scr_same)
    );

    // idle: plan from the caller's value; otherwise from the verified write
    assign stp_work = (q.st == ST_IDLE) ? cur_val : q.wval;
    assign stp_tgt  = (q.st == ST_IDLE) ? scr_tgt : q.tgt;

    lockupd_step #(.DW(DW)) u_step (
        .work (stp_work),
        .tgt  (stp_tgt),
        .ph   (stp_ph),
        .wval (stp_wval)
    );

    always_comb begin
        rd_fail = (q.ph == PH_CLRLD) ? bus_rdata[LD_BIT] : (bus_rdata != q.wval);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.addr = addr_in;
                    d.tgt  = scr_tgt;
                    if (scr_bad) begin
                        d.done = 1'b1;
                        d.err  = E_BADREQ;
                    end else if (scr_same) begin
                        d.done = 1'b1;
                        d.err  = E_OK;
                    end else begin
                        d.ph   = stp_ph;
                        d.wval = stp_wval;
                        d.st   = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (bus_ack) d.st = ST_RD;
            end
            ST_RD: begin
                if (bus_ack) begin
                    if (rd_fail) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        unique case (q.ph)
                            PH_CLRLD: d.err = E_LDSTUCK;
                            PH_SETLD: d.err = E_LDFAIL;
                            default:  d.err = E_RWFAIL;
                        endcase
                    end else if (stp_ph == PH_NONE) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.err  = E_OK;
                    end else begin
                        d.ph   = stp_ph;
                        d.wval = stp_wval;
                        d.st   = ST_WR;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.ph   <= PH_NONE;
            q.tgt  <= '0;
            q.wval <= '0;
            q.addr <= '0;
            q.done <= 1'b0;
            q.err  <= E_OK;
        end else begin
            q <= d;
        end
    end

    assign bus_req   = (q.st != ST_IDLE);
    assign bus_we    = (q.st == ST_WR);
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wval;
    assign done      = q.done;
    assign err_code  = q.err;

    // Last value known to be in the register: the caller's value, then each read-back.
    logic [DW-1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             seen_q <= '0;
        else if (q.st == ST_IDLE && start)      seen_q <= cur_val;
        else if (bus_req && !bus_we && bus_ack) seen_q <= bus_rdata;
    end

    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    a_r7_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_ack |=> bus_req && !bus_we && $stable(bus_addr));

    a_r6_ld_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_wdata[LD_BIT] && !seen_q[LD_BIT]
        |-> ((bus_wdata ^ seen_q) & ACC_M) == '0);

    a_r4_ld_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && seen_q[LD_BIT] && !bus_wdata[LD_BIT]
        |-> ((bus_wdata ^ seen_q) & ~LD_M) == '0);

    a_r2_reject_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_code == E_BADREQ |-> !$past(bus_req));
endmodule

// File: tb/lockupd_ctrl_tb.sv
`timescale 1ns/1ps
module lockupd_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        unlock = 1'b0;
    logic [15:0] addr_in = '0;
    logic [7:0]  cur_val = '0;
    logic [7:0]  req_val = '0;
    logic        done;
    logic [2:0]  err_code;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;

    // register model and knobs
    logic [7:0] mem [0:3];
    bit stuck_ld, freeze_rw, block_ld;
    int lat = 0;
    int wait_cnt = 0;
    int log_n = 0;
    bit          log_we   [0:15];
    logic [15:0] log_addr [0:15];
    logic [7:0]  log_data [0:15];

    always #4 clk = ~clk;

    lockupd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .unlock(unlock),
        .addr_in(addr_in), .cur_val(cur_val), .req_val(req_val),
        .done(done), .err_code(err_code),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (done) done_cnt++;
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    bus_ack  = 1'b1;
                    if (bus_we) begin
                        logic [7:0] old, nv;
                        old = mem[bus_addr[1:0]];
                        nv  = bus_wdata;
                        if (stuck_ld && old[1]) nv[1] = 1'b1;
                        if (freeze_rw) begin nv[0] = old[0]; nv[2] = old[2]; end
                        if (block_ld && !old[1]) nv[1] = 1'b0;
                        mem[bus_addr[1:0]] = nv;
                        if (log_n < 16) begin
                            log_we[log_n] = 1'b1; log_addr[log_n] = bus_addr; log_data[log_n] = bus_wdata;
                        end
                    end else begin
                        bus_rdata = mem[bus_addr[1:0]];
                        if (log_n < 16) begin
                            log_we[log_n] = 1'b0; log_addr[log_n] = bus_addr; log_data[log_n] = bus_rdata;
                        end
                    end
                    log_n++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input int a, input logic [7:0] v);
        stuck_ld = 0; freeze_rw = 0; block_ld = 0; lat = 0;
        mem[a] = v;
        log_n = 0;
    endtask

    task automatic run_op(input int a, input logic [7:0] c, input logic [7:0] r,
                          input bit u, output logic [2:0] e);
        int n;
        @(negedge clk);
        start = 1'b1; addr_in = 16'(a); cur_val = c; req_val = r; unlock = u;
        @(negedge clk);
        start = 1'b0; unlock = 1'b0;
        n = 0;
        while (!done && n < 300) begin @(negedge clk); n++; end
        e = err_code;
        @(negedge clk);
    endtask

    // check one logged access: write or read, address, data
    task automatic chk_acc(input int i, input bit we, input int a, input logic [7:0] v, input string tag);
        chk(log_we[i] == we, tag, int'(log_we[i]), int'(we));
        chk(log_addr[i] == 16'(a), tag, int'(log_addr[i]), a);
        chk(log_data[i] == v, tag, int'(log_data[i]), int'(v));
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R10 done low after reset", int'(done), 0);
        chk(bus_req == 1'b0, "R10 bus idle after reset", int'(bus_req), 0);
    endtask

    task automatic t_reject();
        logic [2:0] e;
        setup(0, 8'h01);
        run_op(0, 8'h01, 8'h09, 0, e);
        chk(e == 3'd1, "R2 upper-bit change rejected (R1 code 1)", int'(e), 1);
        chk(log_n == 0, "R2 no bus access on reject", log_n, 0);
    endtask

    task automatic t_nochange();
        logic [2:0] e;
        setup(0, 8'h43);
        run_op(0, 8'h43, 8'h43, 0, e);
        chk(e == 3'd0, "R3 no-op success", int'(e), 0);
        chk(log_n == 0, "R3 no bus access on no-op", log_n, 0);
    endtask

    task automatic t_access_only();
        logic [2:0] e;
        setup(1, 8'h01);
        run_op(1, 8'h01, 8'h04, 0, e);
        chk(e == 3'd0, "R5 access change ok", int'(e), 0);
        chk(log_n == 2, "R7 one write one read", log_n, 2);
        chk_acc(0, 1, 1, 8'h04, "R5 access write");
        chk_acc(1, 0, 1, 8'h04, "R7 read-back same address");
    endtask

    task automatic t_clear_then_access();
        logic [2:0] e;
        setup(2, 8'h03);
        run_op(2, 8'h03, 8'h04, 0, e);
        chk(e == 3'd0, "R4 release then access ok", int'(e), 0);
        chk(log_n == 4, "R7 two write/read pairs", log_n, 4);
        chk_acc(0, 1, 2, 8'h01, "R4 first write clears only lockdown");
        chk_acc(1, 0, 2, 8'h01, "R7 read after release");
        chk_acc(2, 1, 2, 8'h04, "R5 access write lockdown kept clear");
        chk_acc(3, 0, 2, 8'h04, "R7 read after access write");
    endtask

    task automatic t_access_then_set();
        logic [2:0] e;
        setup(3, 8'h00);
        run_op(3, 8'h00, 8'h07, 0, e);
        chk(e == 3'd0, "R6 full lock ok", int'(e), 0);
        chk(log_n == 4, "R6 separate lockdown write", log_n, 4);
        chk_acc(0, 1, 3, 8'h05, "R5 access bits first with lockdown clear");
        chk_acc(2, 1, 3, 8'h07, "R6 lockdown set last with full value");
        chk(mem[3] == 8'h07, "R6 register final", int'(mem[3]), 7);
    endtask

    task automatic t_stuck();
        logic [2:0] e;
        setup(0, 8'h03); stuck_ld = 1;
        run_op(0, 8'h03, 8'h00, 0, e);
        chk(e == 3'd2, "R4 stuck lockdown code 2", int'(e), 2);
        chk(log_n == 2, "R4 no write after stuck release", log_n, 2);
    endtask

    task automatic t_rw_fail();
        logic [2:0] e;
        setup(1, 8'h00); freeze_rw = 1;
        run_op(1, 8'h00, 8'h05, 0, e);
        chk(e == 3'd3, "R5 access mismatch code 3", int'(e), 3);
        chk(log_n == 2, "R5 stop after mismatch", log_n, 2);
    endtask

    task automatic t_ld_fail();
        logic [2:0] e;
        setup(2, 8'h00); block_ld = 1;
        run_op(2, 8'h00, 8'h02, 0, e);
        chk(e == 3'd4, "R6 lockdown set mismatch code 4", int'(e), 4);
        chk_acc(0, 1, 2, 8'h02, "R6 lockdown-only write");
    endtask

    task automatic t_unlock();
        logic [2:0] e;
        setup(0, 8'h07);
        run_op(0, 8'h07, 8'hFF, 1, e);
        chk(e == 3'd0, "R8 unlock keeps lockdown", int'(e), 0);
        chk_acc(0, 1, 0, 8'h02, "R8 unlock write ignores req_val");
        setup(1, 8'h85);
        run_op(1, 8'h85, 8'h00, 1, e);
        chk(e == 3'd0, "R8 unlock with upper bits", int'(e), 0);
        chk(mem[1] == 8'h80, "R8 upper bits kept", int'(mem[1]), 8'h80);
        setup(2, 8'h02);
        run_op(2, 8'h02, 8'h05, 1, e);
        chk(e == 3'd0 && log_n == 0, "R8 unlock already open no access", log_n, 0);
    endtask

    task automatic t_slow_ack();
        logic [2:0] e;
        setup(3, 8'h00); lat = 3;
        run_op(3, 8'h00, 8'h01, 0, e);
        chk(e == 3'd0, "R9 slow acknowledge ok", int'(e), 0);
        chk_acc(0, 1, 3, 8'h01, "R9 write held to ack");
        lat = 0;
    endtask

    task automatic t_busy();
        logic [2:0] e;
        int base, n;
        setup(0, 8'h00);
        base = done_cnt;
        @(negedge clk);
        start = 1'b1; addr_in = 0; cur_val = 8'h00; req_val = 8'h07; unlock = 0;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        start = 1'b1; cur_val = 8'h01; req_val = 8'h09;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 300) begin @(negedge clk); n++; end
        e = err_code;
        repeat (6) @(negedge clk);
        chk(e == 3'd0, "R10 busy start ignored result", int'(e), 0);
        chk(done_cnt - base == 1, "R10 single done pulse", done_cnt - base, 1);
        chk(log_n == 4, "R10 only first op accesses", log_n, 4);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < 4; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_nochange();
        t_access_only();
        t_clear_then_access();
        t_access_then_set();
        t_stuck();
        t_rw_fail();
        t_ld_fail();
        t_unlock();
        t_slow_ack();
        t_busy();
        report();
    end
endmodule